// File: doc/BRIEF.md
# DSP Instruction Class and Field Decoder

This block takes one 32-bit instruction word of a floating-point DSP together with the address of that instruction. It decodes the word into an instruction class, an addressing mode and a set of operand fields, all extracted and ready to use. For branch words it also works out the destination address. For PC-relative forms this is the current address plus one plus a signed 16-bit offset, and a delayed branch adds a further two.

The decode logic is purely combinational. A single output register stage follows it, loaded only when the input strobe is high, and a valid strobe comes out one cycle later. Words that arrive while the strobe is low are ignored, and the registered results stay as they were. A fetch or issue stage uses the block to hand later stages pre-split fields instead of the raw word. It does not look up mnemonics and it does not execute anything.

Top module: `dsp_insn_decode`

## Requirements
- R1: Class code from the word. With bit 31 set, bit 30 = 0 gives parallel multiply/add (code 3) and bit 30 = 1 gives parallel store (code 4). With bit 31 clear, bits 30:29 decide: 00 or 10 give two-operand (code 0), 01 gives three-operand (code 1), and 11 gives branch (code 2).
- R2: `out_mode` equals word bits 22:21, read as 00 register, 01 direct, 10 indirect, 11 immediate.
- R3: The register fields are as follows. `out_dst` is bits 20:16 and `out_src2` is bits 15:8. `out_src1` is bits 4:0 zero-extended for two-operand words in register mode and for branch words; otherwise it is bits 7:0.
- R4: `out_imm` is bits 15:0 zero-extended for a two-operand word in direct mode. For every other word it is bits 15:0 sign-extended.
- R5: A word whose bits 31:8 equal 0x087000 sets `out_ldp`, and `out_page` becomes bits 7:0 placed at bits 23:16 with zeros below. Any other word gives `out_ldp` = 0 and `out_page` = 0.
- R6: Branch words use bits 28:27 as the branch kind. With kind 10 the target is bits 23:0. With kind 11 (trap) the target is bits 4:0 zero-extended.
- R7: For kind 00 or 01, bit 25 set selects PC-relative. The target is then PC + 1 + sext(bits 15:0), or PC + 3 + sext(bits 15:0) when bit 21 is set, modulo 2^PC_W. `out_delayed` is bit 21 for kinds 00 and 01 of branch words and is 0 for everything else.
- R8: Kind 01 is decrement-and-branch: `out_areg` = bits 24:22, and `out_areg` = 0 for any other word. With kind 00 or 01 and bit 25 clear, the target is 0 and the register is in `out_src1`. Non-branch words give target 0.
- R9: The outputs update one cycle after an input cycle with `in_valid` high, and `out_valid` is high in exactly that cycle.
- R10: While `in_valid` is low, all decoded outputs hold their values.
- R11: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Word and PC are valid this cycle |
| in_word | input | 32 | Instruction word |
| in_pc | input | PC_W | Address of the instruction |
| out_valid | output | 1 | Registered outputs are new this cycle |
| out_class | output | 3 | Class code (R1) |
| out_mode | output | 2 | Addressing mode (R2) |
| out_dst | output | 5 | Destination register field |
| out_src1 | output | 8 | First source field |
| out_src2 | output | 8 | Second source field |
| out_imm | output | IMM_W | Extended 16-bit immediate or displacement |
| out_target | output | PC_W | Branch target |
| out_delayed | output | 1 | Delayed branch flag |
| out_areg | output | 3 | Auxiliary register of decrement-and-branch |
| out_ldp | output | 1 | Load-data-page form detected |
| out_page | output | 24 | Page value of load-data-page |

## Verification
Some properties are checked by the assertions on every cycle:
- the one-cycle strobe latency;
- outputs holding while the strobe is low;
- a set bit 31 always giving one of the two parallel classes;
- the load-data-page flag only ever appearing with a two-operand class in immediate mode and a page with zero low bits;
- the delayed flag and a non-zero auxiliary register only appearing on branches.

The exact field values can only be shown by the bench's scenarios. These include targets across address wrap, the +3 delayed adjustment, sign against zero extension, and the load-data-page near miss.

// File: rtl/dsp_dec_pkg.sv
// Shared types for the instruction decoder: class codes, addressing modes
// and branch kinds. Assumes a fixed 32-bit instruction word.
package dsp_dec_pkg;
    localparam int INSN_W = 32;
    localparam int OFF_W  = 16;

    typedef enum logic [2:0] {
        CLS_TWO    = 3'd0,
        CLS_THREE  = 3'd1,
        CLS_BRANCH = 3'd2,
        CLS_PMAC   = 3'd3,
        CLS_PSTORE = 3'd4
    } cls_e;

    typedef enum logic [1:0] {
        AM_REG = 2'b00,
        AM_DIR = 2'b01,
        AM_IND = 2'b10,
        AM_IMM = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        BK_COND = 2'b00,
        BK_DEC  = 2'b01,
        BK_ABS  = 2'b10,
        BK_TRAP = 2'b11
    } brkind_e;
endpackage

// File: rtl/dec_class_sel.sv
// Class selector: derives the class from a 2-bit field when bit 31 is set,
// otherwise from a 3-bit field. Purely combinational.
module dec_class_sel
    import dsp_dec_pkg::*;
(
    input  logic [INSN_W-1:0] word,
    output cls_e              cls
);
    // Pick the class from the variable-length top field.
    always_comb begin
        if (word[31]) begin
            cls = word[30] ? CLS_PSTORE : CLS_PMAC;
        end else begin
            unique case (word[30:29])
                2'b01:   cls = CLS_THREE;
                2'b11:   cls = CLS_BRANCH;
                default: cls = CLS_TWO;
            endcase
        end
    end
endmodule

// File: rtl/dec_field_pick.sv
// Operand field extractor: mode, register numbers, extended immediate and
// load-data-page detection. Assumes IMM_W >= 16. Combinational.
module dec_field_pick
    import dsp_dec_pkg::*;
#(
    parameter int IMM_W = 32
) (
    input  logic [INSN_W-1:0] word,
    input  cls_e              cls,
    output logic [1:0]        mode,
    output logic [4:0]        dst,
    output logic [7:0]        src1,
    output logic [7:0]        src2,
    output logic [IMM_W-1:0]  imm,
    output logic              ldp,
    output logic [23:0]       page
);
    localparam int EXT_W = IMM_W - OFF_W;
    localparam logic [23:0] LDP_KEY = 24'h087000;

    logic is_reg_two;
    logic is_dir_two;

    // Mode and plain register fields.
    always_comb begin
        mode       = word[22:21];
        dst        = word[20:16];
        src2       = word[15:8];
        is_reg_two = (cls == CLS_TWO) && (word[22:21] == AM_REG);
        is_dir_two = (cls == CLS_TWO) && (word[22:21] == AM_DIR);
    end

    // First source: 5-bit register form or full 8-bit field.
    always_comb begin
        if (is_reg_two || cls == CLS_BRANCH) src1 = {3'b000, word[4:0]};
        else                                 src1 = word[7:0];
    end

    // Immediate: zero-extended direct address, otherwise sign-extended.
    always_comb begin
        if (is_dir_two) imm = {{EXT_W{1'b0}}, word[15:0]};
        else            imm = {{EXT_W{word[15]}}, word[15:0]};
    end

    // Load-data-page detection and page placement.
    always_comb begin
        ldp  = (word[31:8] == LDP_KEY);
        page = ldp ? {word[7:0], 16'h0000} : 24'h000000;
    end
endmodule

// File: rtl/dec_branch_calc.sv
// Branch target unit: absolute, trap and PC-relative targets, delayed flag
// and decrement-and-branch register. Assumes PC_W > 16 and PC_W >= 24.
module dec_branch_calc
    import dsp_dec_pkg::*;
#(
    parameter int PC_W = 24
) (
    input  logic [INSN_W-1:0] word,
    input  logic [PC_W-1:0]   pc,
    input  cls_e              cls,
    output logic [PC_W-1:0]   target,
    output logic              delayed,
    output logic [2:0]        areg
);
    localparam int SX_W = PC_W - OFF_W;

    brkind_e         kind;
    logic            is_br;
    logic            rel_kind;
    logic [PC_W-1:0] offset;
    logic [PC_W-1:0] bump;

    // Classify the branch and prepare the offset and step.
    always_comb begin
        is_br    = (cls == CLS_BRANCH);
        kind     = brkind_e'(word[28:27]);
        rel_kind = is_br && (kind == BK_COND || kind == BK_DEC);
        delayed  = rel_kind && word[21];
        offset   = {{SX_W{word[15]}}, word[15:0]};
        bump     = delayed ? PC_W'(3) : PC_W'(1);
        areg     = (is_br && kind == BK_DEC) ? word[24:22] : 3'b000;
    end

    // Choose the target per branch kind.
    always_comb begin
        target = '0;
        if (is_br) begin
            unique case (kind)
                BK_ABS:  target = PC_W'(word[23:0]);
                BK_TRAP: target = PC_W'(word[4:0]);
                default: target = word[25] ? (pc + bump + offset) : '0;
            endcase
        end
    end
endmodule

// File: rtl/dsp_insn_decode.sv
// Top level: combinational decode of one instruction word followed by one
// register stage loaded on in_valid. out_valid follows in_valid by one
// cycle; outputs hold while in_valid is low. Synchronous active-low reset.
module dsp_insn_decode
    import dsp_dec_pkg::*;
#(
    parameter int PC_W  = 24,
    parameter int IMM_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_word,
    input  logic [PC_W-1:0]   in_pc,
    output logic              out_valid,
    output logic [2:0]        out_class,
    output logic [1:0]        out_mode,
    output logic [4:0]        out_dst,
    output logic [7:0]        out_src1,
    output logic [7:0]        out_src2,
    output logic [IMM_W-1:0]  out_imm,
    output logic [PC_W-1:0]   out_target,
    output logic              out_delayed,
    output logic [2:0]        out_areg,
    output logic              out_ldp,
    output logic [23:0]       out_page
);
    cls_e             c_cls;
    logic [1:0]       c_mode;
    logic [4:0]       c_dst;
    logic [7:0]       c_src1;
    logic [7:0]       c_src2;
    logic [IMM_W-1:0] c_imm;
    logic             c_ldp;
    logic [23:0]      c_page;
    logic [PC_W-1:0]  c_target;
    logic             c_delayed;
    logic [2:0]       c_areg;

    dec_class_sel u_cls (
        .word (in_word),
        .cls  (c_cls)
    );

    dec_field_pick #(.IMM_W(IMM_W)) u_fld (
        .word (in_word),
        .cls  (c_cls),
        .mode (c_mode),
        .dst  (c_dst),
        .src1 (c_src1),
        .src2 (c_src2),
        .imm  (c_imm),
        .ldp  (c_ldp),
        .page (c_page)
    );

    dec_branch_calc #(.PC_W(PC_W)) u_br (
        .word    (in_word),
        .pc      (in_pc),
        .cls     (c_cls),
        .target  (c_target),
        .delayed (c_delayed),
        .areg    (c_areg)
    );

    // Valid strobe delayed by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Output register, loaded only for a valid input word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_class   <= '0;
            out_mode    <= '0;
            out_dst     <= '0;
            out_src1    <= '0;
            out_src2    <= '0;
            out_imm     <= '0;
            out_target  <= '0;
            out_delayed <= 1'b0;
            out_areg    <= '0;
            out_ldp     <= 1'b0;
            out_page    <= '0;
        end else if (in_valid) begin
            out_class   <= c_cls;
            out_mode    <= c_mode;
            out_dst     <= c_dst;
            out_src1    <= c_src1;
            out_src2    <= c_src2;
            out_imm     <= c_imm;
            out_target  <= c_target;
            out_delayed <= c_delayed;
            out_areg    <= c_areg;
            out_ldp     <= c_ldp;
            out_page    <= c_page;
        end
    end
endmodule

// File: rtl/dsp_insn_decode_chk.sv
// Assertion checker for dsp_insn_decode, attached by bind below.
module dsp_insn_decode_chk #(
    parameter int PC_W  = 24,
    parameter int IMM_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [31:0]      in_word,
    input logic [PC_W-1:0]  in_pc,
    input logic             out_valid,
    input logic [2:0]       out_class,
    input logic [1:0]       out_mode,
    input logic [4:0]       out_dst,
    input logic [7:0]       out_src1,
    input logic [7:0]       out_src2,
    input logic [IMM_W-1:0] out_imm,
    input logic [PC_W-1:0]  out_target,
    input logic             out_delayed,
    input logic [2:0]       out_areg,
    input logic             out_ldp,
    input logic [23:0]      out_page
);
    assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_class) && $stable(out_mode) && $stable(out_dst)
                       && $stable(out_src1) && $stable(out_src2) && $stable(out_imm)
                       && $stable(out_target) && $stable(out_delayed)
                       && $stable(out_areg) && $stable(out_ldp) && $stable(out_page)));
    assert_par_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[31]) |=> (out_class == 3'd3 || out_class == 3'd4));
    assert_ldp_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_ldp |-> (out_class == 3'd0 && out_mode == 2'b11 && out_page[15:0] == 16'h0));
    assert_delay_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_delayed |-> out_class == 3'd2);
    assert_areg_branch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_areg != 3'd0) |-> out_class == 3'd2);
endmodule

bind dsp_insn_decode dsp_insn_decode_chk #(.PC_W(PC_W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/dsp_insn_decode_bench.sv
module dsp_insn_decode_bench;
    localparam int PC_W  = 24;
    localparam int IMM_W = 32;

    typedef struct packed {
        logic [31:0] w;
        logic [23:0] pc;
        logic [2:0]  cls;
        logic [31:0] imm;
        logic [23:0] tgt;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{32'h0005_0003, 24'h000000, 3'd0, 32'h0000_0003, 24'h000000},
        '{32'h4060_FFFE, 24'h000000, 3'd0, 32'hFFFF_FFFE, 24'h000000},
        '{32'h0022_8001, 24'h000000, 3'd0, 32'h0000_8001, 24'h000000},
        '{32'h2000_1234, 24'h000000, 3'd1, 32'h0000_1234, 24'h000000},
        '{32'h8000_0000, 24'h000000, 3'd3, 32'h0000_0000, 24'h000000},
        '{32'hC000_FFFF, 24'h000000, 3'd4, 32'hFFFF_FFFF, 24'h000000},
        '{32'h70AB_CDEF, 24'h000010, 3'd2, 32'hFFFF_CDEF, 24'hABCDEF},
        '{32'h7800_0015, 24'h000010, 3'd2, 32'h0000_0015, 24'h000015},
        '{32'h6200_0010, 24'h000100, 3'd2, 32'h0000_0010, 24'h000111},
        '{32'h6220_FFFC, 24'h000100, 3'd2, 32'hFFFF_FFFC, 24'h0000FF},
        '{32'h6200_0001, 24'hFFFFFF, 3'd2, 32'h0000_0001, 24'h000001},
        '{32'h6B40_0008, 24'h000020, 3'd2, 32'h0000_0008, 24'h000029}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [31:0]      in_word = '0;
    logic [PC_W-1:0]  in_pc = '0;
    logic             out_valid;
    logic [2:0]       out_class;
    logic [1:0]       out_mode;
    logic [4:0]       out_dst;
    logic [7:0]       out_src1;
    logic [7:0]       out_src2;
    logic [IMM_W-1:0] out_imm;
    logic [PC_W-1:0]  out_target;
    logic             out_delayed;
    logic [2:0]       out_areg;
    logic             out_ldp;
    logic [23:0]      out_page;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dsp_insn_decode #(.PC_W(PC_W), .IMM_W(IMM_W)) u_dsp_insn_decode (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one valid word; on return the registered result is visible.
    task automatic apply(input logic [31:0] w, input logic [23:0] pc);
        @(negedge clk);
        in_word  = w;
        in_pc    = pc;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #1_600_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 valid", 32'(out_valid), 32'd0);
        chk("R11 target", 32'(out_target), 32'd0);
        chk("R11 imm", out_imm, 32'd0);
        chk("R11 page", 32'(out_page), 32'd0);
        rst_n = 1'b1;

        // R1 R4 R6 R7 R8: table walk
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].w, VEC[i].pc);
            chk($sformatf("R9 valid v%0d", i), 32'(out_valid), 32'd1);
            chk($sformatf("R1 class v%0d", i), 32'(out_class), 32'(VEC[i].cls));
            chk($sformatf("R4 imm v%0d", i), out_imm, VEC[i].imm);
            chk($sformatf("R6 R7 R8 target v%0d", i), 32'(out_target), 32'(VEC[i].tgt));
        end

        // R2 R3: direct-mode two-operand fields
        apply(32'h0022_8001, 24'h0);
        chk("R2 mode direct", 32'(out_mode), 32'd1);
        chk("R3 dst", 32'(out_dst), 32'd2);
        chk("R3 src1 8-bit", 32'(out_src1), 32'h01);
        chk("R3 src2", 32'(out_src2), 32'h80);
        // R3: register-mode source trimmed to 5 bits
        apply(32'h0005_00E3, 24'h0);
        chk("R2 mode reg", 32'(out_mode), 32'd0);
        chk("R3 src1 5-bit", 32'(out_src1), 32'h03);
        // R3: three-operand keeps full 8-bit sources
        apply(32'h2040_ABCD, 24'h0);
        chk("R3 three src1", 32'(out_src1), 32'hCD);
        chk("R3 three src2", 32'(out_src2), 32'hAB);
        chk("R2 three mode", 32'(out_mode), 32'd2);

        // R5: load-data-page and near miss
        apply(32'h0870_0042, 24'h0);
        chk("R5 ldp flag", 32'(out_ldp), 32'd1);
        chk("R5 page", 32'(out_page), 32'h420000);
        apply(32'h0870_0142, 24'h0);
        chk("R5 near miss flag", 32'(out_ldp), 32'd0);
        chk("R5 near miss page", 32'(out_page), 32'd0);

        // R7: delayed flag, R8: decrement register
        apply(32'h6220_FFFC, 24'h000100);
        chk("R7 delayed", 32'(out_delayed), 32'd1);
        chk("R8 areg none", 32'(out_areg), 32'd0);
        apply(32'h6B40_0008, 24'h000020);
        chk("R8 areg", 32'(out_areg), 32'd5);
        chk("R7 not delayed", 32'(out_delayed), 32'd0);
        // R7: bit 21 of an absolute branch is address, not delay
        apply(32'h7020_0000, 24'h0);
        chk("R7 abs no delay", 32'(out_delayed), 32'd0);
        chk("R6 abs target", 32'(out_target), 32'h200000);
        // R8: register-form branch
        apply(32'h6000_0007, 24'h000050);
        chk("R8 reg target", 32'(out_target), 32'd0);
        chk("R8 reg src1", 32'(out_src1), 32'd7);

        // R9 R10: word ignored while strobe low
        in_word = 32'hC0FF_FFFF;
        in_pc   = 24'h123456;
        @(negedge clk);
        chk("R9 valid low", 32'(out_valid), 32'd0);
        chk("R10 hold class", 32'(out_class), 32'd2);
        chk("R10 hold src1", 32'(out_src1), 32'd7);
        chk("R10 hold imm", out_imm, 32'd7);

        // R11: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 re-reset class", 32'(out_class), 32'd0);
        chk("R11 re-reset src1", 32'(out_src1), 32'd0);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule